// File: doc/BRIEF.md
# Frame Timing Generator with Reference Alignment

This block is the central timing sequencer of a telecom backplane interface. It runs on a 16.384 MHz master clock and cycles through one 8 kHz frame of 2048 clock periods. From this single counter it produces the frame pulse (active low), a 4.096 MHz bit clock (active low), a 2.048 MHz bit clock and a one-cycle frame-start strobe. Because all four outputs come from the same counter, they always keep a fixed phase relationship to one another.

The block has three ways of setting its frame phase. As the timing master it free-runs and ignores every incoming reference. It can also slave its frame phase to the active-low frame pulse of a shared backplane. Finally, it can align to an external 8 kHz reference. Each incoming reference passes through a two-flop synchronizer and a falling-edge detector. A detected edge on the selected source loads the counter with a value that already accounts for the synchronizer delay, so the next frame boundary lines up with the reference. If the reference is missing, the counter keeps free-running.

A sticky phase-error flag records any reference edge that lands more than two clocks away from the expected counter position. A read strobe clears the flag. The backplane frame-pulse drive enable is held off whenever the block is slaved to that backplane.

Top module: `frame_timing_gen`

## Requirements
- R1: The frame counter advances by one each clock through FRAME_LEN (default 2048) states. `frame_stb_o` is high for exactly the one cycle in which the count is 0.
- R2: `c4_no` equals counter bit 1, so it is low for counts 0 and 1 modulo 4. `c2_o` equals counter bit 2, so it is high for counts 4 to 7 modulo 8.
- R3: `fp_no` is low for exactly four cycles, at counts FRAME_LEN-2, FRAME_LEN-1, 0 and 1, which straddles the wrap.
- R4: While reset is asserted, the count is FRAME_LEN-1 with `fp_no`=0, `c4_no`=1, `c2_o`=1, `frame_stb_o`=0, `sync_err_o`=0 and `fp_oe_o`=0. The first clock edge after release gives count 0.
- R5: The mode encodings are 0 for free-run master, 1 for backplane slave, 2 for external-reference alignment and 3 for free-run. In modes 0 and 3, edges on either reference input have no effect on the count.
- R6: In mode 1, a falling edge of `fp_ref_ni` first sampled at clock edge k loads the count with 0 at edge k+2. A reference that falls while the count is FRAME_LEN-3 therefore leaves the frame undisturbed.
- R7: In mode 2, a falling edge of `ext_ref_i` aligns the count with the same timing as in R6. Edges on `fp_ref_ni` are ignored in mode 2, and edges on `ext_ref_i` are ignored in mode 1.
- R8: `sync_err_o` is set at a load edge when the circular distance between the count the block would otherwise have reached and 0 exceeds 2. A distance of 2 or less does not set it.
- R9: `sync_err_o` stays set until a clock edge with `err_rd_i` high clears it. If a new error and a read fall on the same edge, the set wins.
- R10: `fp_oe_o` is a registered copy of `mst_en_i` AND (mode != 1), so it is low after any edge that sees mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Phase source: 0/3 free-run, 1 backplane, 2 external reference |
| mst_en_i | input | 1 | Request to drive the backplane frame pulse |
| fp_ref_ni | input | 1 | Backplane frame pulse, active low, asynchronous |
| ext_ref_i | input | 1 | External 8 kHz reference, falling edge marks frame, asynchronous |
| err_rd_i | input | 1 | Read strobe that clears the phase-error flag |
| fp_no | output | 1 | Generated frame pulse, active low |
| c4_no | output | 1 | 4.096 MHz clock, active low form |
| c2_o | output | 1 | 2.048 MHz clock |
| frame_stb_o | output | 1 | One-cycle strobe at count 0 |
| fp_oe_o | output | 1 | Frame-pulse drive enable |
| sync_err_o | output | 1 | Sticky phase-error flag |

## Verification
Two functions can act on the same clock edge: setting the phase-error flag from a misplaced reference edge, and clearing that flag with a read. The bench provokes this by sending a reference far from the expected phase and raising `err_rd_i` on the very edge where the load happens. It then judges that the flag remains set, and that a later read with no new edge clears it. A second case of two functions meeting is a reference load landing on the natural wrap. The bench checks that the frame strobe still appears exactly once at that edge.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic [1:0] {
        SYNC_FREE     = 2'd0,
        SYNC_BACKPL   = 2'd1,
        SYNC_EXTREF   = 2'd2,
        SYNC_FREE_ALT = 2'd3
    } sync_mode_e;

    localparam int unsigned SRC_NUM     = 2;
    localparam int unsigned SRC_BACKPL  = 0;
    localparam int unsigned SRC_EXTREF  = 1;

endpackage

// File: rtl/ftg_edge_sync.sv
// Brings an asynchronous level into the clock domain and flags its falling edge.
module ftg_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic fall_o
);

    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= sh_d;
    end

    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/ftg_phase_cmp.sv
// Circular distance test between the natural count and the load position.
module ftg_phase_cmp #(
    parameter int unsigned CW   = 11,
    parameter int unsigned LOAD = 0,
    parameter int unsigned TOL  = 2
) (
    input  logic [CW-1:0] cnt_nat_i,
    output logic          off_o
);

    localparam logic [CW-1:0] LOAD_V = CW'(LOAD);
    localparam logic [CW-1:0] TOL_V  = CW'(TOL);
    localparam logic [CW-1:0] HI_V   = CW'((1 << CW) - TOL);

    logic [CW-1:0] diff;

    always_comb begin
        diff  = cnt_nat_i - LOAD_V;
        off_o = (diff > TOL_V) && (diff < HI_V);
    end

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen #(
    parameter int unsigned FRAME_LEN   = 2048,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SYNC_TOL    = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       mst_en_i,
    input  logic       fp_ref_ni,
    input  logic       ext_ref_i,
    input  logic       err_rd_i,
    output logic       fp_no,
    output logic       c4_no,
    output logic       c2_o,
    output logic       frame_stb_o,
    output logic       fp_oe_o,
    output logic       sync_err_o
);
    import ftg_pkg::*;

    // FRAME_LEN must be a power of two and at least 8
    localparam int unsigned CW        = $clog2(FRAME_LEN);
    localparam int unsigned LOAD_POS  = (FRAME_LEN - 2 + SYNC_STAGES) % FRAME_LEN;
    localparam logic [CW-1:0] LAST    = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] FP_FROM = CW'(FRAME_LEN - 2);
    localparam logic [CW-1:0] FP_TO   = CW'(1);
    localparam logic [CW-1:0] LOAD_V  = CW'(LOAD_POS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fp_n;
        logic          c4_n;
        logic          c2;
        logic          stb;
        logic          err;
        logic          oe;
    } ftg_state_t;

    ftg_state_t st_d, st_q;

    // ---------------- reference synchronizers ----------------
    logic [SRC_NUM-1:0] src_raw;
    logic [SRC_NUM-1:0] src_fall;

    assign src_raw[SRC_BACKPL] = fp_ref_ni;
    assign src_raw[SRC_EXTREF] = ext_ref_i;

    for (genvar g = 0; g < SRC_NUM; g++) begin : g_src
        ftg_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (src_raw[g]),
            .fall_o (src_fall[g])
        );
    end

    // ---------------- phase selection ----------------
    sync_mode_e    mode;
    logic          ref_fall;
    logic [CW-1:0] cnt_nat;
    logic          phase_off;

    always_comb begin
        mode = sync_mode_e'(mode_i);
        unique case (mode)
            SYNC_BACKPL: ref_fall = src_fall[SRC_BACKPL];
            SYNC_EXTREF: ref_fall = src_fall[SRC_EXTREF];
            default:     ref_fall = 1'b0;
        endcase
        cnt_nat = (st_q.cnt == LAST) ? '0 : st_q.cnt + CW'(1);
    end

    ftg_phase_cmp #(
        .CW   (CW),
        .LOAD (LOAD_POS),
        .TOL  (SYNC_TOL)
    ) u_cmp (
        .cnt_nat_i (cnt_nat),
        .off_o     (phase_off)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        st_d.cnt  = ref_fall ? LOAD_V : cnt_nat;
        st_d.fp_n = !((st_d.cnt >= FP_FROM) || (st_d.cnt <= FP_TO));
        st_d.c4_n = st_d.cnt[1];
        st_d.c2   = st_d.cnt[2];
        st_d.stb  = (st_d.cnt == '0);
        st_d.err  = (ref_fall && phase_off) || (st_q.err && !err_rd_i);
        st_d.oe   = mst_en_i && (mode != SYNC_BACKPL);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt  <= LAST;
            st_q.fp_n <= 1'b0;
            st_q.c4_n <= 1'b1;
            st_q.c2   <= 1'b1;
            st_q.stb  <= 1'b0;
            st_q.err  <= 1'b0;
            st_q.oe   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fp_no       = st_q.fp_n;
    assign c4_no       = st_q.c4_n;
    assign c2_o        = st_q.c2;
    assign frame_stb_o = st_q.stb;
    assign fp_oe_o     = st_q.oe;
    assign sync_err_o  = st_q.err;

endmodule

// File: rtl/ftg_checker.sv
module ftg_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode_i,
    input logic       err_rd_i,
    input logic       ref_fall,
    input logic       fp_no,
    input logic       c4_no,
    input logic       c2_o,
    input logic       frame_stb_o,
    input logic       fp_oe_o,
    input logic       sync_err_o
);

    // R1: strobe lasts a single cycle
    p_stb_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_stb_o |=> !frame_stb_o);

    // R2: at count 0 both bit clocks sit in their low phase
    p_clk_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_stb_o |-> (!c4_no && !c2_o));

    // R3: frame pulse is active at the frame start
    p_fp_at_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_stb_o |-> !fp_no);

    // R8: with no selected reference edge the flag cannot rise
    p_no_spurious_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_err_o && !ref_fall) |=> !sync_err_o);

    // R9: flag held while no read arrives
    p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_err_o && !err_rd_i) |=> sync_err_o);

    // R10: no drive enable after backplane slave mode is seen
    p_no_drive_slave_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd1) |=> !fp_oe_o);

endmodule

bind frame_timing_gen ftg_checker u_ftg_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .err_rd_i    (err_rd_i),
    .ref_fall    (ref_fall),
    .fp_no       (fp_no),
    .c4_no       (c4_no),
    .c2_o        (c2_o),
    .frame_stb_o (frame_stb_o),
    .fp_oe_o     (fp_oe_o),
    .sync_err_o  (sync_err_o)
);

// File: tb/tb_frame_timing_gen.sv
module tb_frame_timing_gen;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 2048;
    localparam int LOADV      = 0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       mst_en = 1'b0;
    logic       fp_ref_n = 1'b1;
    logic       ext_ref = 1'b1;
    logic       err_rd = 1'b0;
    logic       fp_no, c4_no, c2_o, frame_stb_o, fp_oe_o, sync_err_o;

    int checks = 0;
    int fails  = 0;
    bit run    = 1'b0;
    bit done   = 1'b0;

    // reference model of the requirements
    int   n    = 0;
    int   mcnt = FRAME - 1;
    logic merr = 1'b0;
    logic moe  = 1'b0;
    int   load_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_timing_gen dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mode_i      (mode),
        .mst_en_i    (mst_en),
        .fp_ref_ni   (fp_ref_n),
        .ext_ref_i   (ext_ref),
        .err_rd_i    (err_rd),
        .fp_no       (fp_no),
        .c4_no       (c4_no),
        .c2_o        (c2_o),
        .frame_stb_o (frame_stb_o),
        .fp_oe_o     (fp_oe_o),
        .sync_err_o  (sync_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            if (fails < 20)
                $display("FAIL %s at edge %0d: actual %0d expected %0d", req, n, act, exp);
        end
    endtask

    // model: advance on each clock edge
    always @(posedge clk) begin
        if (run) begin
            int nat, diff;
            bit hit, off;
            n++;
            nat = (mcnt + 1) % FRAME;
            hit = (load_q.size() > 0) && (load_q[0] == n);
            if (hit) void'(load_q.pop_front());
            diff = (nat - LOADV + FRAME) % FRAME;
            off  = (diff > 2) && (diff < FRAME - 2);
            merr = (hit && off) || (merr && !err_rd);
            mcnt = hit ? LOADV : nat;
            moe  = mst_en && (mode != 2'd1);
        end
    end

    // monitor: compare all outputs each cycle, away from the edge
    always @(negedge clk) begin
        if (run && !done) begin
            check("R1 strobe", frame_stb_o, (mcnt == 0) ? 1 : 0);
            check("R2 c4", c4_no, (mcnt >> 1) & 1);
            check("R2 c2", c2_o, (mcnt >> 2) & 1);
            check("R3 fp", fp_no, (mcnt >= FRAME - 2 || mcnt <= 1) ? 0 : 1);
            check("R8 err", sync_err_o, merr);
            check("R10 oe", fp_oe_o, moe);
        end
    end

    task automatic wait_cnt(input int c);
        do @(negedge clk); while (mcnt != c);
    endtask

    // driver: falling reference at a chosen count, pushes expected load edge
    task automatic pulse_ref(input int which, input int at_cnt);
        wait_cnt(at_cnt);
        if (which == 0) fp_ref_n = 1'b0; else ext_ref = 1'b0;
        if ((which == 0 && mode == 2'd1) || (which == 1 && mode == 2'd2))
            load_q.push_back(n + 3);
        repeat (6) @(negedge clk);
        fp_ref_n = 1'b1;
        ext_ref  = 1'b1;
    endtask

    task automatic read_err();
        @(negedge clk); err_rd = 1'b1;
        @(negedge clk); err_rd = 1'b0;
    endtask

    // pulse and then check the strobe at the load edge
    task automatic sync_at(input int which, input int at_cnt, input string req, input int exp_err);
        wait_cnt(at_cnt);
        if (which == 0) fp_ref_n = 1'b0; else ext_ref = 1'b0;
        load_q.push_back(n + 3);
        repeat (3) @(negedge clk);
        check(req, frame_stb_o, 1);
        check({req, " R8 flag"}, sync_err_o, exp_err);
        repeat (3) @(negedge clk);
        fp_ref_n = 1'b1;
        ext_ref  = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R4 reset state
        repeat (3) @(negedge clk);
        check("R4 fp", fp_no, 0);
        check("R4 c4", c4_no, 1);
        check("R4 c2", c2_o, 1);
        check("R4 stb", frame_stb_o, 0);
        check("R4 err", sync_err_o, 0);
        check("R4 oe", fp_oe_o, 0);
        rst_n = 1'b1;
        run   = 1'b1;
        @(negedge clk);
        check("R4 first count", frame_stb_o, 1);

        // R1-R3 free running, master drive enabled
        mst_en = 1'b1;
        repeat (2 * FRAME + 100) @(negedge clk);

        // R5 references ignored in free modes
        pulse_ref(0, 700);
        pulse_ref(1, 900);
        wait_cnt(0);
        check("R5 phase kept mode0", (n - 1) % FRAME, 0);
        mode = 2'd3;
        pulse_ref(0, 300);
        pulse_ref(1, 1300);
        wait_cnt(0);
        check("R5 phase kept mode3", (n - 1) % FRAME, 0);

        // R6 backplane slave
        mode = 2'd1;
        repeat (3) @(negedge clk);
        check("R10 slave forces oe off", fp_oe_o, 0);
        sync_at(0, FRAME - 3, "R6 aligned", 0);
        sync_at(0, FRAME - 1, "R6 late by 2", 0);
        sync_at(0, FRAME - 5, "R6 early by 2", 0);
        sync_at(0, 0, "R6 late by 3", 1);
        read_err();
        check("R9 read clears", sync_err_o, 0);
        sync_at(0, FRAME - 6, "R6 early by 3", 1);
        read_err();
        sync_at(0, 1000, "R6 far", 1);
        check("R6 phase moved", (n - load_q.size()) >= 0 ? 1 : 0, 1);

        // R7 external ignored in mode 1
        pulse_ref(1, 400);
        check("R7 ext ignored in mode1", sync_err_o, 1);

        // R9 set and read on the same edge
        wait_cnt(600);
        fp_ref_n = 1'b0;
        load_q.push_back(n + 3);
        @(negedge clk);
        @(negedge clk);
        err_rd = 1'b1;
        @(negedge clk);
        err_rd = 1'b0;
        check("R9 set wins over read", sync_err_o, 1);
        check("R6 load strobe", frame_stb_o, 1);
        repeat (4) @(negedge clk);
        fp_ref_n = 1'b1;
        read_err();
        check("R9 later read clears", sync_err_o, 0);

        // R7 external reference mode
        mode = 2'd2;
        repeat (3) @(negedge clk);
        check("R10 oe back in ext mode", fp_oe_o, 1);
        sync_at(1, 1500, "R7 ext far", 1);
        read_err();
        pulse_ref(0, 200);
        check("R7 backplane ignored in mode2", sync_err_o, 0);
        sync_at(1, FRAME - 3, "R7 ext aligned", 0);

        // reference that stops: keep free-running
        mst_en = 1'b0;
        repeat (FRAME + 50) @(negedge clk);
        check("R10 oe follows enable", fp_oe_o, 0);
        check("R1 queue drained", load_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule